// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block merges five reset requests into one system reset output and records in a sticky status word which of them fired. The five requests are an active-low external pin, a software reset strobe, a watchdog expiry, a hard-trap priority conflict and a supply-low comparator. The pin passes through a two-flop synchronizer and a low-pulse filter. A watchdog expiry that arrives while the core sleeps or idles does not reset anything. It raises a one-cycle wake request instead. A supply-low event holds the reset through a combined brown-out and power-up delay, and that delay starts over if the supply dips again.

The cause flags survive every reset they record. Software clears them only by writing zeros through the status-write port. No reset source touches any clock selection, and the block has no output for one. The block's own `rst_n` acts as the power-on reset. It starts the power-up delay with all flags cleared.

Top module: `rstctl_top`

## Requirements
- R1: The external pin causes a reset only after its synchronized level has stayed low for FILT_LEN consecutive clock edges. A low pulse lasting fewer than FILT_LEN cycles leaves `sys_rst` low and leaves cause bit 7 clear.
- R2: A qualified pin reset keeps `sys_rst` high while the pin stays low. It releases within four cycles after the pin returns high.
- R3: A one-cycle `swr_strobe` drives `sys_rst` high for exactly the one cycle that follows the strobe edge.
- R4: A watchdog expiry while neither `sleep_mode` nor `idle_mode` is set drives `sys_rst` high combinationally, in the same cycle as the expiry.
- R5: A watchdog expiry while `sleep_mode` or `idle_mode` is set gives a one-cycle `wake_req` pulse in the next cycle. It does not raise `sys_rst` and does not set cause bit 4.
- R6: A reset request is raised when `trap_req_vld` is set, both `trap_req_lvl` and `trap_act_lvl` lie in 13..15, and the requested level is below the level in service. That request gives a one-cycle `sys_rst` in the next cycle. Equal or higher requested levels, and levels outside 13..15, cause nothing.
- R7: While `bor_low` is high, `sys_rst` is high. After `bor_low` falls, `sys_rst` stays high for BOR_DLY+PWRT_DLY more cycles and then falls.
- R8: If `bor_low` rises again during that delay, the full delay restarts from the next fall of `bor_low`.
- R9: The cause bit positions are: 15 for a trap conflict, 7 for the pin, 6 for a software reset, 4 for a watchdog reset and 1 for brown-out. All other bits always read 0. If several sources fire in the same cycle, all of their bits are set.
- R10: Cause bits are sticky. A `stat_we` write clears each bit whose `stat_wdata` bit is 0 and leaves the bits written as 1 unchanged. A source that sets a bit in the same cycle as a clearing write wins.
- R11: While `rst_n` is low, `sys_rst` is 1, `wake_req` is 0 and `rst_cause` is 0. After `rst_n` is released, `sys_rst` stays high for the brown-out plus power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| swr_strobe | input | 1 | Software reset instruction pulse |
| wdt_expire | input | 1 | Watchdog time-out strobe |
| sleep_mode | input | 1 | Core is in sleep |
| idle_mode | input | 1 | Core is in idle |
| trap_req_vld | input | 1 | A trap is being requested |
| trap_req_lvl | input | 4 | Priority level of the requested trap |
| trap_act_lvl | input | 4 | Priority level of the trap in service |
| bor_low | input | 1 | Supply is below the brown-out threshold |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 16 | Status write data; a 0 clears the matching flag |
| sys_rst | output | 1 | System reset, active high |
| wake_req | output | 1 | Wake request pulse from a watchdog expiry while asleep |
| rst_cause | output | 16 | Sticky reset-cause flags |

## Verification
A vector table drives single-cycle events and combinations of them. It compares the watchdog expiry awake, asleep and idle, which separates the combinational reset from the wake pulse. It also pairs trap levels as lower, equal, higher and non-hard, so only a true lower-priority hard trap counts as a conflict. One joint vector fires several sources in the same cycle to show that flags accumulate. Directed tests then hold the pin low just short of and beyond the filter length. They also release the supply once cleanly and once with a second dip inside the delay, which tells a restarted delay from one that keeps counting. Flag-write tests write ones and zeros, and collide a set with a clear in the same cycle.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned BIT_TRAP = 15;
  localparam int unsigned BIT_PIN  = 7;
  localparam int unsigned BIT_SWR  = 6;
  localparam int unsigned BIT_WDT  = 4;
  localparam int unsigned BIT_BOR  = 1;
  localparam logic [LVL_W-1:0] HARD_LO = 4'd13;
  localparam logic [LVL_W-1:0] HARD_HI = 4'd15;

  typedef enum logic [1:0] {
    BOR_RUN  = 2'd0,
    BOR_LOW  = 2'd1,
    BOR_WAIT = 2'd2
  } bor_state_e;

  typedef struct packed {
    logic trap;
    logic pin;
    logic swr;
    logic wdt;
    logic bor;
  } cause_evt_t;
endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_rst
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q, sync_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;
  logic          low;

  assign low = ~sync_q[1];

  always_comb begin
    sync_d = {sync_q[0], pin_n};
    cnt_d  = cnt_q;
    rst_d  = rst_q;
    if (!low) begin
      cnt_d = '0;
      rst_d = 1'b0;
    end else if (!rst_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        rst_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      rst_q  <= rst_d;
    end
  end

  assign pin_rst = rst_q;

  // R1: the reset can only begin while the synchronized pin is low
  a_r1_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(low));
  // R2: a high synchronized pin releases the reset at the next edge
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    !low |=> !rst_q);
endmodule

// File: rtl/rstctl_bor_seq.sv
module rstctl_bor_seq
  import rstctl_pkg::*;
#(
  parameter int unsigned BOR_DLY  = 64,
  parameter int unsigned PWRT_DLY = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bor_low,
  output logic bor_rst
);
  localparam int unsigned TOT = BOR_DLY + PWRT_DLY;
  localparam int unsigned CW  = $clog2(TOT + 1);

  bor_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      BOR_RUN: begin
        if (bor_low) state_d = BOR_LOW;
      end
      BOR_LOW: begin
        if (!bor_low) begin
          state_d = BOR_WAIT;
          cnt_d   = '0;
        end
      end
      BOR_WAIT: begin
        if (bor_low) begin
          state_d = BOR_LOW;
          cnt_d   = '0;
        end else if (cnt_q == CW'(TOT - 1)) begin
          state_d = BOR_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = BOR_LOW;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BOR_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign bor_rst = (state_q != BOR_RUN);

  // R8: any dip forces the hold state at the next edge
  a_r8_dip_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    bor_low |=> (state_q == BOR_LOW));
  // R7: the delay does not end before the count completes
  a_r7_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BOR_WAIT && !bor_low && cnt_q < CW'(TOT - 1)) |=> (state_q == BOR_WAIT));
endmodule

// File: rtl/rstctl_trap_chk.sv
module rstctl_trap_chk
  import rstctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0] act_lvl,
  output logic             conflict,
  output logic             trap_rst
);
  logic req_hard, act_hard;
  logic rst_q;

  assign req_hard = (req_lvl >= HARD_LO) && (req_lvl <= HARD_HI);
  assign act_hard = (act_lvl >= HARD_LO) && (act_lvl <= HARD_HI);
  assign conflict = req_vld && req_hard && act_hard && (req_lvl < act_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= conflict;
  end

  assign trap_rst = rst_q;

  // R6: a trap reset always follows a lower-level hard request
  a_r6_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> ($past(req_vld) && $past(req_lvl) < $past(act_lvl) && $past(req_lvl) >= HARD_LO));
endmodule

// File: rtl/rstctl_cause_reg.sv
module rstctl_cause_reg
  import rstctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cause_evt_t        evt,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] set_vec, flags_q, flags_d;

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_TRAP] = evt.trap;
    set_vec[BIT_PIN]  = evt.pin;
    set_vec[BIT_SWR]  = evt.swr;
    set_vec[BIT_WDT]  = evt.wdt;
    set_vec[BIT_BOR]  = evt.bor;
    flags_d = flags_q;
    if (wr_en) flags_d = flags_q & wr_data;
    flags_d = flags_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign status = flags_q;

  // R10: without a write, no flag falls
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status & $past(status)) == $past(status)));
  // R10: a set beats a simultaneous clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt.swr |=> status[BIT_SWR]);
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned FILT_LEN = 16,
  parameter int unsigned BOR_DLY  = 64,
  parameter int unsigned PWRT_DLY = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_rst_n,
  input  logic        swr_strobe,
  input  logic        wdt_expire,
  input  logic        sleep_mode,
  input  logic        idle_mode,
  input  logic        trap_req_vld,
  input  logic [3:0]  trap_req_lvl,
  input  logic [3:0]  trap_act_lvl,
  input  logic        bor_low,
  input  logic        stat_we,
  input  logic [15:0] stat_wdata,
  output logic        sys_rst,
  output logic        wake_req,
  output logic [15:0] rst_cause
);
  logic       pin_rst, bor_rst, trap_rst, trap_conflict;
  logic       swr_q, wake_q, wake_d;
  logic       dozing, wdt_now;
  cause_evt_t evt;

  rstctl_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_rst_n), .pin_rst(pin_rst)
  );

  rstctl_bor_seq #(.BOR_DLY(BOR_DLY), .PWRT_DLY(PWRT_DLY)) u_bor (
    .clk(clk), .rst_n(rst_n), .bor_low(bor_low), .bor_rst(bor_rst)
  );

  rstctl_trap_chk u_trap (
    .clk(clk), .rst_n(rst_n), .req_vld(trap_req_vld), .req_lvl(trap_req_lvl),
    .act_lvl(trap_act_lvl), .conflict(trap_conflict), .trap_rst(trap_rst)
  );

  assign dozing  = sleep_mode | idle_mode;
  assign wdt_now = wdt_expire & ~dozing;
  assign wake_d  = wdt_expire & dozing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swr_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      swr_q  <= swr_strobe;
      wake_q <= wake_d;
    end
  end

  always_comb begin
    evt.trap = trap_conflict;
    evt.pin  = pin_rst;
    evt.swr  = swr_strobe;
    evt.wdt  = wdt_now;
    evt.bor  = bor_low;
  end

  rstctl_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(stat_we),
    .wr_data(stat_wdata), .status(rst_cause)
  );

  assign sys_rst  = pin_rst | swr_q | trap_rst | bor_rst | wdt_now;
  assign wake_req = wake_q;

  // R3: software strobe resets in the following cycle
  a_r3_swr_reset: assert property (@(posedge clk) disable iff (!rst_n)
    swr_strobe |=> sys_rst);
  // R4: awake watchdog expiry resets in the same cycle
  a_r4_wdt_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire && !sleep_mode && !idle_mode) |-> sys_rst);
  // R5: watchdog expiry while dozing wakes instead
  a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire && (sleep_mode || idle_mode)) |=> wake_req);
  // R5: wake pulse only follows an expiry
  a_r5_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(wdt_expire));
  // R7: supply low holds the reset
  a_r7_bor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bor_low |=> sys_rst);
endmodule

// File: tb/test_rstctl_top.sv
module test_rstctl_top;
  localparam int unsigned FILT = 8;
  localparam int unsigned BD   = 10;
  localparam int unsigned PD   = 20;
  localparam int unsigned TOT  = BD + PD;

  typedef struct packed {
    logic        swr;
    logic        wdt;
    logic        slp;
    logic        idl;
    logic        tv;
    logic [3:0]  tl;
    logic [3:0]  al;
    logic        now;
    logic        nxt;
    logic        wake;
    logic [15:0] flags;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd0, 4'd0, 1'b0,1'b1,1'b0,16'h0040}, // R3 swr
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd0, 4'd0, 1'b1,1'b1,1'b0,16'h0010}, // R4 wdt awake
    '{1'b0,1'b1,1'b1,1'b0,1'b0,4'd0, 4'd0, 1'b0,1'b0,1'b1,16'h0000}, // R5 sleep
    '{1'b0,1'b1,1'b0,1'b1,1'b0,4'd0, 4'd0, 1'b0,1'b0,1'b1,16'h0000}, // R5 idle
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd13,4'd14,1'b0,1'b1,1'b0,16'h8000}, // R6 conflict
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd14,4'd13,1'b0,1'b0,1'b0,16'h0000}, // R6 higher
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd15,4'd15,1'b0,1'b0,1'b0,16'h0000}, // R6 equal
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd12,4'd14,1'b0,1'b0,1'b0,16'h0000}, // R6 not hard
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'd13,4'd15,1'b1,1'b1,1'b0,16'h8050}, // R9 joint
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd13,4'd14,1'b0,1'b0,1'b0,16'h0000}  // R6 no valid
  };

  logic        clk = 1'b0;
  logic        rst_n, ext_rst_n, swr_strobe, wdt_expire, sleep_mode, idle_mode;
  logic        trap_req_vld, bor_low, stat_we;
  logic [3:0]  trap_req_lvl, trap_act_lvl;
  logic [15:0] stat_wdata;
  logic        sys_rst, wake_req;
  logic [15:0] rst_cause;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  rstctl_top #(.FILT_LEN(FILT), .BOR_DLY(BD), .PWRT_DLY(PD)) i_rstctl_top (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .swr_strobe(swr_strobe),
    .wdt_expire(wdt_expire), .sleep_mode(sleep_mode), .idle_mode(idle_mode),
    .trap_req_vld(trap_req_vld), .trap_req_lvl(trap_req_lvl), .trap_act_lvl(trap_act_lvl),
    .bor_low(bor_low), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .sys_rst(sys_rst), .wake_req(wake_req), .rst_cause(rst_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clear_flags();
    stat_we    = 1'b1;
    stat_wdata = 16'h0000;
    step(1);
    stat_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic seen;
    rst_n = 1'b0; ext_rst_n = 1'b1; swr_strobe = 1'b0; wdt_expire = 1'b0;
    sleep_mode = 1'b0; idle_mode = 1'b0; trap_req_vld = 1'b0;
    trap_req_lvl = 4'd0; trap_act_lvl = 4'd0; bor_low = 1'b0;
    stat_we = 1'b0; stat_wdata = 16'h0;
    step(3);
    check("R11 sys_rst in reset", 32'(sys_rst), 32'd1);
    check("R11 cause in reset", 32'(rst_cause), 32'd0);
    check("R11 wake in reset", 32'(wake_req), 32'd0);
    rst_n = 1'b1;
    step(TOT - 5);
    check("R11 power-up hold", 32'(sys_rst), 32'd1);
    step(10);
    check("R11 power-up release", 32'(sys_rst), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      swr_strobe = VECS[i].swr; wdt_expire = VECS[i].wdt;
      sleep_mode = VECS[i].slp; idle_mode = VECS[i].idl;
      trap_req_vld = VECS[i].tv; trap_req_lvl = VECS[i].tl; trap_act_lvl = VECS[i].al;
      #2;
      check($sformatf("R4 vec%0d same-cycle reset", i), 32'(sys_rst), 32'(VECS[i].now));
      step(1);
      check($sformatf("R3 R6 vec%0d next-cycle reset", i), 32'(sys_rst), 32'(VECS[i].nxt));
      check($sformatf("R5 vec%0d wake", i), 32'(wake_req), 32'(VECS[i].wake));
      check($sformatf("R9 vec%0d flags", i), 32'(rst_cause), 32'(VECS[i].flags));
      swr_strobe = 1'b0; wdt_expire = 1'b0; sleep_mode = 1'b0; idle_mode = 1'b0;
      trap_req_vld = 1'b0;
      step(1);
      check($sformatf("R3 vec%0d reset one cycle", i), 32'(sys_rst), 32'd0);
      check($sformatf("R5 vec%0d wake one cycle", i), 32'(wake_req), 32'd0);
      clear_flags();
    end

    // R1 short pin pulse filtered
    seen = 1'b0;
    ext_rst_n = 1'b0;
    for (int k = 0; k < int'(FILT) - 1; k++) begin
      step(1);
      seen = seen | sys_rst;
    end
    ext_rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1);
      seen = seen | sys_rst;
    end
    check("R1 short pulse no reset", 32'(seen), 32'd0);
    check("R1 short pulse no flag", 32'(rst_cause), 32'd0);

    // R1 R2 long pin pulse
    ext_rst_n = 1'b0;
    step(FILT + 3);
    check("R1 long pulse reset", 32'(sys_rst), 32'd1);
    check("R9 pin flag bit7", 32'(rst_cause), 32'h80);
    step(5);
    check("R2 held while low", 32'(sys_rst), 32'd1);
    ext_rst_n = 1'b1;
    step(4);
    check("R2 released", 32'(sys_rst), 32'd0);
    check("R10 flag sticky after release", 32'(rst_cause), 32'h80);
    stat_we = 1'b1; stat_wdata = 16'hFFFF;
    step(1);
    stat_we = 1'b0;
    check("R10 write one keeps flag", 32'(rst_cause), 32'h80);
    clear_flags();
    check("R10 write zero clears", 32'(rst_cause), 32'd0);

    // R10 set beats clear
    swr_strobe = 1'b1; stat_we = 1'b1; stat_wdata = 16'h0000;
    step(1);
    swr_strobe = 1'b0; stat_we = 1'b0;
    check("R10 set wins over clear", 32'(rst_cause), 32'h40);
    step(2);
    clear_flags();

    // R7 brown-out
    bor_low = 1'b1;
    step(3);
    check("R7 held while low", 32'(sys_rst), 32'd1);
    check("R9 bor flag bit1", 32'(rst_cause), 32'h2);
    bor_low = 1'b0;
    step(TOT - 3);
    check("R7 held through delay", 32'(sys_rst), 32'd1);
    step(7);
    check("R7 released after delay", 32'(sys_rst), 32'd0);
    clear_flags();

    // R8 restart
    bor_low = 1'b1;
    step(2);
    bor_low = 1'b0;
    step(25);
    bor_low = 1'b1;
    step(1);
    bor_low = 1'b0;
    step(TOT - 3);
    check("R8 restarted delay still holding", 32'(sys_rst), 32'd1);
    step(7);
    check("R8 released after restart", 32'(sys_rst), 32'd0);
    check("R9 unused bits zero", 32'(rst_cause & 16'h7F2D), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule